// File: doc/BRIEF.md
# Interval Timer Register Front End

This block is the byte-wide register interface that sits in front of three counting engines of a programmable interval timer. A 2-bit address picks the port. Ports 0, 1 and 2 are the data ports of the three channels. Port 3 takes control words and cannot be read back. The front end decodes each control word. It gathers 16-bit count values out of one or two byte writes, and it hands each value to its channel with a one-cycle load strobe.

On the read side, each channel keeps its own byte pointers for reads and for writes. A channel can freeze its running count in a latch, either through a latch command or through a read-back command. The read-back command can also freeze a status byte, and it can act on several channels in one write. A data read drains these latches in a fixed priority: the status byte first, then the latched count, then the live count. The counting engines are outside the block. They receive a load strobe, a load value, the mode and the BCD flag. They return their live count and their output level.

Reads are combinational. `rdata` is valid while `rd_en` is high, and any pointer or latch state that the read changes is updated at the next rising clock edge. If a write and a read occur in the same cycle, the write takes priority and the read is dropped.

Top module: `timer_ctrl_port`

## Requirements
- R1: After reset, every channel is in word access (code 3) with mode 0 and BCD 0. No count latch and no status latch are pending, and both byte pointers are at the low byte.
- R2: A write to port 3 with bits 7:6 equal to n (n < 3) and bits 5:4 not zero stores bits 5:4 as the access code of channel n. Access code 1 is low byte only, 2 is high byte only, and 3 is low byte then high byte. The same write stores bits 3:1 as the mode and bit 0 as BCD.
- R3: A control word that sets an access code returns the read pointer and the write pointer of that channel to the low byte.
- R4: In low-only access, a data write loads `{8'h00, byte}`. In high-only access, a data write loads `{byte, 8'h00}`.
- R5: In word access, the first data write is held and loads nothing. The second data write loads `{second, first}`. Every load asserts that channel's `load_stb` bit for exactly the one cycle after the write edge, with `load_val` valid in that cycle.
- R6: A control word with bits 5:4 equal to 0 latches the live count of the selected channel. The following data reads return the latched bytes in the order of the access code, and the latch is released after the last of those bytes.
- R7: A count latch request is ignored while an unread latched count is still pending on that channel.
- R8: A port 3 write with bits 7:6 equal to 3 is a read-back command. Bit 1+n selects channel n. Bit 5 low requests a count latch and bit 4 low requests a status latch, and both can be requested on several channels at once. Channels that are not selected are unaffected.
- R9: The status byte holds the output level in bit 7, 0 in bit 6, the access code in bits 5:4, the mode in bits 3:1 and BCD in bit 0. A status latch request is ignored while a status byte is still pending.
- R10: A data read returns a pending status byte and clears it. If no status byte is pending, the read returns a latched count byte. If neither is pending, it returns a live count byte.
- R11: A live read in word access alternates between the low byte and the high byte. A live read in low-only or high-only access always returns that one byte.
- R12: A read of port 3 returns 0 and changes no channel state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| addr | input | 2 | Port select: 0 to 2 are data ports, 3 is control |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, combinational while rd_en is high |
| live_count | input | NCH*16 | Running count of each channel, channel n at bits 16n+15:16n |
| out_level | input | NCH | Output level of each channel |
| load_stb | output | NCH | One-cycle count load strobe for each channel |
| load_val | output | NCH*16 | Count value for each channel, valid while its strobe is high |
| chan_mode | output | NCH*3 | Programmed mode of each channel |
| chan_bcd | output | NCH | Programmed BCD flag of each channel |

## Verification
Some properties are checked on every clock cycle:
- A pending count latch keeps its value until it is read.
- A pending status byte stays pending and unchanged until it is read.
- Every control word that sets an access code leaves both pointers at the low byte.
- The first byte of a word write never raises a load strobe.
- At most one channel accepts a control word in any cycle.
- A port 3 read returns 0.

Other behaviour can only be shown by the bench's scenarios:
- the values loaded into the channels
- the order in which status, latched and live bytes come out
- a second latch request being ignored
- channels that a read-back command does not select being left unaffected

// File: rtl/timer_ctrl_pkg.sv
package timer_ctrl_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 16;
    localparam int MODE_W = 3;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'd0,
        ACC_LO    = 2'd1,
        ACC_HI    = 2'd2,
        ACC_WORD  = 2'd3
    } acc_e;

    typedef struct packed {
        acc_e              acc;
        logic [MODE_W-1:0] mode;
        logic              bcd;
        logic              wr_hi;
        logic [BYTE_W-1:0] hold;
        logic              rd_hi;
        acc_e              lat_st;
        logic [CNT_W-1:0]  lat_val;
        logic              sts_pend;
        logic [BYTE_W-1:0] sts_val;
        logic              load_stb;
        logic [CNT_W-1:0]  load_val;
    } chan_state_t;

    localparam chan_state_t CHAN_RESET = '{
        acc:      ACC_WORD,
        mode:     '0,
        bcd:      1'b0,
        wr_hi:    1'b0,
        hold:     '0,
        rd_hi:    1'b0,
        lat_st:   ACC_LATCH,
        lat_val:  '0,
        sts_pend: 1'b0,
        sts_val:  '0,
        load_stb: 1'b0,
        load_val: '0
    };
endpackage

// File: rtl/timer_ctrl_decode.sv
module timer_ctrl_decode
    import timer_ctrl_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [NCH-1:0]    ctl_set,
    output logic [NCH-1:0]    cnt_latch,
    output logic [NCH-1:0]    sts_latch,
    output logic [NCH-1:0]    wr_stb,
    output logic [NCH-1:0]    rd_stb
);
    localparam logic [1:0] CTL_PORT = 2'd3;

    logic ctl_wr;
    logic readback;
    acc_e acc_field;

    assign ctl_wr    = wr_en && (addr == CTL_PORT);
    assign readback  = ctl_wr && (wdata[7:6] == 2'd3);
    assign acc_field = acc_e'(wdata[5:4]);

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        logic sel_norm;
        logic sel_rb;
        assign sel_norm     = ctl_wr && (wdata[7:6] == 2'(n));
        assign sel_rb       = readback && wdata[1+n];
        assign ctl_set[n]   = sel_norm && (acc_field != ACC_LATCH);
        assign cnt_latch[n] = (sel_norm && (acc_field == ACC_LATCH)) || (sel_rb && !wdata[5]);
        assign sts_latch[n] = sel_rb && !wdata[4];
        assign wr_stb[n]    = wr_en && (addr == 2'(n));
        assign rd_stb[n]    = rd_en && !wr_en && (addr == 2'(n));
    end

    // R2: a control word programs at most one channel
    assert_one_ctl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ctl_set));
endmodule

// File: rtl/timer_ctrl_chan.sv
module timer_ctrl_chan
    import timer_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_set,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              cnt_latch,
    input  logic              sts_latch,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic [CNT_W-1:0]  live,
    input  logic              out_lvl,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              load_stb,
    output logic [CNT_W-1:0]  load_val,
    output logic [MODE_W-1:0] mode,
    output logic              bcd
);
    localparam int HB = CNT_W - 1;

    chan_state_t d, q;

    always_comb begin
        d          = q;
        d.load_stb = 1'b0;

        if (rd_stb) begin
            if (q.sts_pend) begin
                d.sts_pend = 1'b0;
            end else if (q.lat_st != ACC_LATCH) begin
                d.lat_st = (q.lat_st == ACC_WORD) ? ACC_HI : ACC_LATCH;
            end else if (q.acc == ACC_WORD) begin
                d.rd_hi = ~q.rd_hi;
            end
        end

        if (cnt_latch && (q.lat_st == ACC_LATCH)) begin
            d.lat_st  = q.acc;
            d.lat_val = live;
        end

        if (sts_latch && !q.sts_pend) begin
            d.sts_pend = 1'b1;
            d.sts_val  = {out_lvl, 1'b0, q.acc, q.mode, q.bcd};
        end

        if (ctl_set) begin
            d.acc   = acc_e'(wdata[5:4]);
            d.mode  = wdata[3:1];
            d.bcd   = wdata[0];
            d.wr_hi = 1'b0;
            d.rd_hi = 1'b0;
        end

        if (wr_stb) begin
            unique case (q.acc)
                ACC_LO: begin
                    d.load_stb = 1'b1;
                    d.load_val = {{BYTE_W{1'b0}}, wdata};
                end
                ACC_HI: begin
                    d.load_stb = 1'b1;
                    d.load_val = {wdata, {BYTE_W{1'b0}}};
                end
                ACC_WORD: begin
                    if (!q.wr_hi) begin
                        d.hold  = wdata;
                        d.wr_hi = 1'b1;
                    end else begin
                        d.load_stb = 1'b1;
                        d.load_val = {wdata, q.hold};
                        d.wr_hi    = 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= CHAN_RESET;
        else        q <= d;
    end

    always_comb begin
        if (q.sts_pend) begin
            rd_byte = q.sts_val;
        end else if (q.lat_st != ACC_LATCH) begin
            rd_byte = (q.lat_st == ACC_HI) ? q.lat_val[HB -: BYTE_W] : q.lat_val[BYTE_W-1:0];
        end else begin
            unique case (q.acc)
                ACC_HI:   rd_byte = live[HB -: BYTE_W];
                ACC_WORD: rd_byte = q.rd_hi ? live[HB -: BYTE_W] : live[BYTE_W-1:0];
                default:  rd_byte = live[BYTE_W-1:0];
            endcase
        end
    end

    assign load_stb = q.load_stb;
    assign load_val = q.load_val;
    assign mode     = q.mode;
    assign bcd      = q.bcd;

    assert_word_first_no_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !ctl_set && q.acc == ACC_WORD && !q.wr_hi) |=> !q.load_stb);

    assert_latch_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.lat_st != ACC_LATCH && !rd_stb) |=> $stable(q.lat_val));

    assert_status_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sts_pend && !rd_stb) |=> (q.sts_pend && $stable(q.sts_val)));

    assert_ptr_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_set |=> (!q.wr_hi && !q.rd_hi));
endmodule

// File: rtl/timer_ctrl_port.sv
module timer_ctrl_port
    import timer_ctrl_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [1:0]            addr,
    input  logic [7:0]            wdata,
    output logic [7:0]            rdata,
    input  logic [NCH*16-1:0]     live_count,
    input  logic [NCH-1:0]        out_level,
    output logic [NCH-1:0]        load_stb,
    output logic [NCH*16-1:0]     load_val,
    output logic [NCH*3-1:0]      chan_mode,
    output logic [NCH-1:0]        chan_bcd
);
    logic [NCH-1:0] ctl_set, cnt_latch, sts_latch, wr_stb, rd_stb;
    logic [BYTE_W-1:0] ch_rd [NCH];

    timer_ctrl_decode #(.NCH(NCH)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (addr),
        .wdata     (wdata),
        .ctl_set   (ctl_set),
        .cnt_latch (cnt_latch),
        .sts_latch (sts_latch),
        .wr_stb    (wr_stb),
        .rd_stb    (rd_stb)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_chan
        timer_ctrl_chan u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .ctl_set   (ctl_set[n]),
            .wdata     (wdata),
            .cnt_latch (cnt_latch[n]),
            .sts_latch (sts_latch[n]),
            .wr_stb    (wr_stb[n]),
            .rd_stb    (rd_stb[n]),
            .live      (live_count[n*CNT_W +: CNT_W]),
            .out_lvl   (out_level[n]),
            .rd_byte   (ch_rd[n]),
            .load_stb  (load_stb[n]),
            .load_val  (load_val[n*CNT_W +: CNT_W]),
            .mode      (chan_mode[n*MODE_W +: MODE_W]),
            .bcd       (chan_bcd[n])
        );
    end

    always_comb begin
        rdata = '0;
        for (int n = 0; n < NCH; n++) begin
            if (rd_stb[n]) rdata = ch_rd[n];
        end
    end

    assert_ctl_read_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && addr == 2'd3) |-> (rdata == 8'h00));
endmodule

// File: tb/timer_ctrl_port_test.sv
module timer_ctrl_port_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [NCH*16-1:0] live_count;
    logic [NCH-1:0] out_level = 3'b101;
    logic [NCH-1:0] load_stb;
    logic [NCH*16-1:0] load_val;
    logic [NCH*3-1:0] chan_mode;
    logic [NCH-1:0] chan_bcd;

    int n_tests = 0, n_fail = 0;
    logic [7:0] rb;

    always #(CLK_PERIOD/2) clk = ~clk;

    timer_ctrl_port #(.NCH(NCH)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .live_count(live_count), .out_level(out_level),
        .load_stb(load_stb), .load_val(load_val), .chan_mode(chan_mode), .chan_bcd(chan_bcd)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic set_live(input int ch, input logic [15:0] v);
        live_count[ch*16 +: 16] = v;
    endtask

    task automatic t_reset;
        bus_wr(2'd3, 8'hEE);
        bus_rd(2'd0, rb); check("R1 ch0 status", rb, 8'hB0);
        bus_rd(2'd1, rb); check("R1 ch1 status", rb, 8'h30);
        bus_rd(2'd2, rb); check("R1 ch2 status", rb, 8'hB0);
        bus_rd(2'd0, rb); check("R11 ch0 live low", rb, 8'h34);
        bus_rd(2'd0, rb); check("R11 ch0 live high", rb, 8'h12);
    endtask

    task automatic t_word_load;
        bus_wr(2'd3, 8'h74);
        check("R2 ch1 mode", chan_mode[5:3], 3'd2);
        bus_wr(2'd1, 8'h56);
        check("R5 first byte no load", load_stb, 3'b000);
        bus_wr(2'd1, 8'h78);
        check("R5 second byte strobe", load_stb, 3'b010);
        check("R5 word value", load_val[31:16], 16'h7856);
        @(negedge clk);
        check("R5 strobe one cycle", load_stb, 3'b000);
    endtask

    task automatic t_byte_modes;
        bus_wr(2'd3, 8'h96);
        bus_wr(2'd2, 8'h42);
        check("R4 low-only strobe", load_stb, 3'b100);
        check("R4 low-only value", load_val[47:32], 16'h0042);
        bus_wr(2'd3, 8'hA6);
        bus_wr(2'd2, 8'h99);
        check("R4 high-only value", load_val[47:32], 16'h9900);
        bus_rd(2'd2, rb); check("R11 high-only read 1", rb, 8'h0F);
        bus_rd(2'd2, rb); check("R11 high-only read 2", rb, 8'h0F);
        bus_wr(2'd3, 8'h96);
        bus_rd(2'd2, rb); check("R11 low-only read", rb, 8'h0E);
    endtask

    task automatic t_ptr_reset;
        bus_wr(2'd3, 8'h30);
        bus_wr(2'd0, 8'h11);
        bus_wr(2'd3, 8'h34);
        bus_wr(2'd0, 8'h22);
        check("R3 write pointer reset, no load", load_stb, 3'b000);
        bus_wr(2'd0, 8'h33);
        check("R3 load after reset pointer", load_val[15:0], 16'h3322);
        bus_rd(2'd0, rb);
        bus_wr(2'd3, 8'h30);
        bus_rd(2'd0, rb); check("R3 read pointer reset", rb, 8'h34);
    endtask

    task automatic t_latch;
        bus_wr(2'd3, 8'h40);
        set_live(1, 16'h5A5A);
        bus_wr(2'd3, 8'h40);
        bus_rd(2'd1, rb); check("R6 latched low", rb, 8'hCD);
        bus_rd(2'd1, rb); check("R7 second latch ignored", rb, 8'hAB);
        set_live(1, 16'h1357);
        bus_rd(2'd1, rb); check("R6 released, live low", rb, 8'h57);
        bus_rd(2'd1, rb); check("R11 live high", rb, 8'h13);
        bus_wr(2'd3, 8'h80);
        set_live(2, 16'h4321);
        bus_rd(2'd2, rb); check("R6 low-only latched", rb, 8'h0E);
        bus_rd(2'd2, rb); check("R6 low-only released", rb, 8'h21);
        set_live(2, 16'h0F0E);
    endtask

    task automatic t_readback;
        bus_wr(2'd3, 8'hCA);
        out_level = 3'b000;
        set_live(0, 16'h0000);
        set_live(2, 16'h7777);
        bus_wr(2'd3, 8'hEA);
        bus_rd(2'd0, rb); check("R10 ch0 status first", rb, 8'hB0);
        bus_rd(2'd0, rb); check("R8 ch0 latched low", rb, 8'h34);
        bus_rd(2'd0, rb); check("R8 ch0 latched high", rb, 8'h12);
        bus_rd(2'd0, rb); check("R10 ch0 live after drain", rb, 8'h00);
        bus_rd(2'd2, rb); check("R9 ch2 status kept", rb, 8'h96);
        bus_rd(2'd2, rb); check("R8 ch2 latched", rb, 8'h0E);
        bus_rd(2'd2, rb); check("R10 ch2 live", rb, 8'h77);
        bus_rd(2'd1, rb); check("R8 ch1 unselected live", rb, 8'h57);
    endtask

    task automatic t_ctl_read;
        bus_rd(2'd3, rb); check("R12 port 3 reads 0", rb, 8'h00);
        bus_rd(2'd1, rb); check("R12 no pointer change", rb, 8'h13);
    endtask

    task automatic t_status_bcd;
        out_level = 3'b010;
        bus_wr(2'd3, 8'h75);
        check("R2 ch1 bcd", chan_bcd, 3'b010);
        bus_wr(2'd3, 8'hE4);
        bus_rd(2'd1, rb); check("R9 status format", rb, 8'hB5);
    endtask

    initial begin
        live_count = {16'h0F0E, 16'hABCD, 16'h1234};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset no strobe", load_stb, 3'b000);
        check("R1 reset mode", chan_mode, 9'd0);
        t_reset();
        t_word_load();
        t_byte_modes();
        t_ptr_reset();
        t_latch();
        t_readback();
        t_ctl_read();
        t_status_bcd();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule